// File: doc/BRIEF.md
# Multi-Warp Register Scoreboard

This block keeps a record, for each resident warp, of which architectural registers are still waiting for a result. When an instruction issues, its destination register is marked busy for the issuing warp. When a result is written back, the matching bit is cleared. The block reads the source register IDs of every warp's next instruction in parallel and looks them up against that warp's busy set. From this it produces a registered ready flag per warp that an issue selector can use directly.

Only read-after-write dependencies hold a warp back. Within a warp, instructions issue in program order, so the destination of the next instruction is not examined. Two further inputs per warp also mask readiness: one says the execution unit the warp needs has no free slot, and the other says the warp is held at a barrier. The barrier logic and the execution units live outside this block.

Eligibility is computed from the busy state as it will be after the current edge. A writeback therefore frees a dependent warp in the same result cycle, with no extra bubble. An issue likewise blocks a dependent read straight away.

Top module: `warp_scoreboard`

## Requirements
- R1: A synchronous active-high reset clears every busy bit and drives `eligible` and `raw_hazard` to all zeros. After reset is released, no valid source of any warp is reported as a hazard.
- R2: An issue (`iss_vld`=1, `iss_dst_vld`=1) marks register `iss_dst` of warp `iss_warp` busy. A valid source of that warp naming that register gives `raw_hazard`=1 and `eligible`=0 in the result due one cycle later.
- R3: An issue with `iss_dst_vld`=0, or with `iss_vld`=0, marks no register busy.
- R4: A writeback (`wb_vld`=1) clears register `wb_reg` of warp `wb_warp`. A source naming only that register is ready in the result due one cycle later.
- R5: When an issue and a writeback name the same warp and register in one cycle, the register ends up busy.
- R6: Busy state is separate per warp. An issue by one warp never creates a hazard for another warp that reads the same register number.
- R7: Each warp has `NUM_SRC` source slots. Slot s of warp w uses bits `[(w*NUM_SRC+s)*REG_W +: REG_W]` of `src_reg` and bit `w*NUM_SRC+s` of `src_vld`. A slot whose valid bit is 0 is ignored in the hazard check.
- R8: `unit_busy[w]`=1 forces `eligible[w]`=0 in the result due one cycle later, whatever the hazard state.
- R9: `bar_wait[w]`=1 forces `eligible[w]`=0 in the result due one cycle later, whatever the hazard state.
- R10: A writeback and an issue to a different register of the same warp in one cycle both take effect. A source reading the freed register is ready at once, with no added cycle.
- R11: A busy register that none of the warp's valid sources names does not stall the warp (no write-after-write or write-after-read check).
- R12: `raw_hazard[w]` reports only the operand check. It is independent of `unit_busy` and `bar_wait`. `eligible[w]`=1 is only possible when `raw_hazard[w]`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 1 | An instruction issues this cycle |
| iss_warp | input | WARP_W | Warp that issues |
| iss_dst | input | REG_W | Destination register of the issued instruction |
| iss_dst_vld | input | 1 | The issued instruction writes a register |
| wb_vld | input | 1 | A result is written back this cycle |
| wb_warp | input | WARP_W | Warp owning the written-back register |
| wb_reg | input | REG_W | Register written back |
| src_reg | input | NUM_WARPS*NUM_SRC*REG_W | Source register IDs of every warp's next instruction |
| src_vld | input | NUM_WARPS*NUM_SRC | Valid flag per source slot |
| unit_busy | input | NUM_WARPS | Needed execution unit is full, per warp |
| bar_wait | input | NUM_WARPS | Warp waits at a barrier |
| eligible | output | NUM_WARPS | Registered ready-to-issue flag per warp |
| raw_hazard | output | NUM_WARPS | Registered operand-not-ready flag per warp |

## Verification
Every result is due exactly one clock after the edge that samples its stimulus. Both outputs reflect the issue, the writeback, the source fields and the mask inputs presented at that edge, so there is no added bypass delay. The bench drives inputs on the falling edge and updates its model on the rising edge from those same inputs. It compares at the next falling edge, one register stage later. Reset is checked from the first falling edge after a reset edge. Directed sweeps visit every warp and register pair of a small configuration, and a pseudo-random run compares against the model on every cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Action applied to one busy bit on a clock edge.
  typedef enum logic [1:0] {
    BIT_KEEP  = 2'd0,
    BIT_SET   = 2'd1,
    BIT_CLEAR = 2'd2
  } bit_op_e;

  // An issue that names a bit outranks a writeback naming the same bit.
  function automatic bit_op_e resolve_op(input logic set_hit, input logic clr_hit);
    if (set_hit) return BIT_SET;
    if (clr_hit) return BIT_CLEAR;
    return BIT_KEEP;
  endfunction

endpackage

// File: rtl/sb_pending_row.sv
module sb_pending_row
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 64,
  parameter int REG_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_en,
  input  logic [REG_W-1:0]    set_reg,
  input  logic                clr_en,
  input  logic [REG_W-1:0]    clr_reg,
  output logic [NUM_REGS-1:0] pend_next
);

  logic [NUM_REGS-1:0] pend_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_bit
    bit_op_e op;
    logic    bit_nx;

    always_comb begin
      op = resolve_op(set_en && (set_reg == REG_W'(r)),
                      clr_en && (clr_reg == REG_W'(r)));
      unique case (op)
        BIT_SET:   bit_nx = 1'b1;
        BIT_CLEAR: bit_nx = 1'b0;
        default:   bit_nx = pend_q[r];
      endcase
    end

    assign pend_next[r] = bit_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_next;
  end

endmodule

// File: rtl/sb_src_check.sv
module sb_src_check #(
  parameter int NUM_REGS = 64,
  parameter int REG_W    = 6,
  parameter int NUM_SRC  = 3
) (
  input  logic [NUM_REGS-1:0]      pend,
  input  logic [NUM_SRC*REG_W-1:0] src_reg,
  input  logic [NUM_SRC-1:0]       src_vld,
  output logic                     hazard
);

  logic [NUM_SRC-1:0] hit;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign hit[s] = src_vld[s] && pend[src_reg[s*REG_W +: REG_W]];
  end

  assign hazard = |hit;

endmodule

// File: rtl/sb_elig_stage.sv
module sb_elig_stage #(
  parameter int NUM_WARPS = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] hazard,
  input  logic [NUM_WARPS-1:0] unit_busy,
  input  logic [NUM_WARPS-1:0] bar_wait,
  output logic [NUM_WARPS-1:0] eligible,
  output logic [NUM_WARPS-1:0] raw_hazard
);

  always_ff @(posedge clk) begin
    if (rst) begin
      eligible   <= '0;
      raw_hazard <= '0;
    end else begin
      eligible   <= ~hazard & ~unit_busy & ~bar_wait;
      raw_hazard <= hazard;
    end
  end

endmodule

// File: rtl/warp_scoreboard.sv
module warp_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_WARPS = 12,
  parameter int NUM_REGS  = 64,
  parameter int NUM_SRC   = 3,
  parameter int WARP_W    = $clog2(NUM_WARPS),
  parameter int REG_W     = $clog2(NUM_REGS)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               iss_vld,
  input  logic [WARP_W-1:0]                  iss_warp,
  input  logic [REG_W-1:0]                   iss_dst,
  input  logic                               iss_dst_vld,
  input  logic                               wb_vld,
  input  logic [WARP_W-1:0]                  wb_warp,
  input  logic [REG_W-1:0]                   wb_reg,
  input  logic [NUM_WARPS*NUM_SRC*REG_W-1:0] src_reg,
  input  logic [NUM_WARPS*NUM_SRC-1:0]       src_vld,
  input  logic [NUM_WARPS-1:0]               unit_busy,
  input  logic [NUM_WARPS-1:0]               bar_wait,
  output logic [NUM_WARPS-1:0]               eligible,
  output logic [NUM_WARPS-1:0]               raw_hazard
);

  localparam int SLOT_BITS = NUM_SRC * REG_W;

  logic                 iss_write;
  logic [NUM_WARPS-1:0] hazard_now;

  assign iss_write = iss_vld && iss_dst_vld;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic                set_en;
    logic                clr_en;
    logic [NUM_REGS-1:0] pend_next;

    assign set_en = iss_write && (iss_warp == WARP_W'(w));
    assign clr_en = wb_vld    && (wb_warp  == WARP_W'(w));

    sb_pending_row #(
      .NUM_REGS (NUM_REGS),
      .REG_W    (REG_W)
    ) u_row (
      .clk       (clk),
      .rst       (rst),
      .set_en    (set_en),
      .set_reg   (iss_dst),
      .clr_en    (clr_en),
      .clr_reg   (wb_reg),
      .pend_next (pend_next)
    );

    sb_src_check #(
      .NUM_REGS (NUM_REGS),
      .REG_W    (REG_W),
      .NUM_SRC  (NUM_SRC)
    ) u_chk (
      .pend    (pend_next),
      .src_reg (src_reg[w*SLOT_BITS +: SLOT_BITS]),
      .src_vld (src_vld[w*NUM_SRC +: NUM_SRC]),
      .hazard  (hazard_now[w])
    );
  end

  sb_elig_stage #(
    .NUM_WARPS (NUM_WARPS)
  ) u_elig (
    .clk        (clk),
    .rst        (rst),
    .hazard     (hazard_now),
    .unit_busy  (unit_busy),
    .bar_wait   (bar_wait),
    .eligible   (eligible),
    .raw_hazard (raw_hazard)
  );

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int NUM_WARPS = 12,
  parameter int NUM_REGS  = 64,
  parameter int NUM_SRC   = 3,
  parameter int WARP_W    = $clog2(NUM_WARPS),
  parameter int REG_W     = $clog2(NUM_REGS)
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               iss_vld,
  input logic [WARP_W-1:0]                  iss_warp,
  input logic [REG_W-1:0]                   iss_dst,
  input logic                               iss_dst_vld,
  input logic                               wb_vld,
  input logic [WARP_W-1:0]                  wb_warp,
  input logic [REG_W-1:0]                   wb_reg,
  input logic [NUM_WARPS*NUM_SRC*REG_W-1:0] src_reg,
  input logic [NUM_WARPS*NUM_SRC-1:0]       src_vld,
  input logic [NUM_WARPS-1:0]               unit_busy,
  input logic [NUM_WARPS-1:0]               bar_wait,
  input logic [NUM_WARPS-1:0]               eligible,
  input logic [NUM_WARPS-1:0]               raw_hazard
);

  logic rst_seen = 1'b0;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst_seen) begin
      AST_RESET_CLEAR: assert (eligible == '0 && raw_hazard == '0); // R1
    end
  end

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_w
    logic [REG_W-1:0] slot0;
    assign slot0 = src_reg[(w*NUM_SRC)*REG_W +: REG_W];

    AST_UNIT_BUSY_MASK: assert property (@(posedge clk) disable iff (rst)
      unit_busy[w] |=> !eligible[w]); // R8

    AST_BARRIER_MASK: assert property (@(posedge clk) disable iff (rst)
      bar_wait[w] |=> !eligible[w]); // R9

    AST_READY_NEEDS_OPERANDS: assert property (@(posedge clk) disable iff (rst)
      eligible[w] |-> !raw_hazard[w]); // R12

    AST_ISSUE_MARKS_BUSY: assert property (@(posedge clk) disable iff (rst)
      (iss_vld && iss_dst_vld && iss_warp == WARP_W'(w) &&
       src_vld[w*NUM_SRC] && slot0 == iss_dst) |=> raw_hazard[w]); // R2

    AST_WB_FREES_REG: assert property (@(posedge clk) disable iff (rst)
      (wb_vld && wb_warp == WARP_W'(w) && !(iss_vld && iss_warp == WARP_W'(w)) &&
       src_vld[w*NUM_SRC +: NUM_SRC] == NUM_SRC'(1) && slot0 == wb_reg)
      |=> !raw_hazard[w]); // R4
  end

endmodule

bind warp_scoreboard sb_checker #(
  .NUM_WARPS (NUM_WARPS),
  .NUM_REGS  (NUM_REGS),
  .NUM_SRC   (NUM_SRC),
  .WARP_W    (WARP_W),
  .REG_W     (REG_W)
) u_sb_checker (
  .clk         (clk),
  .rst         (rst),
  .iss_vld     (iss_vld),
  .iss_warp    (iss_warp),
  .iss_dst     (iss_dst),
  .iss_dst_vld (iss_dst_vld),
  .wb_vld      (wb_vld),
  .wb_warp     (wb_warp),
  .wb_reg      (wb_reg),
  .src_reg     (src_reg),
  .src_vld     (src_vld),
  .unit_busy   (unit_busy),
  .bar_wait    (bar_wait),
  .eligible    (eligible),
  .raw_hazard  (raw_hazard)
);

// File: tb/warp_scoreboard_test.sv
module warp_scoreboard_test;

  localparam int W  = 4;
  localparam int R  = 8;
  localparam int S  = 2;
  localparam int WW = 2;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_vld = 0, iss_dst_vld = 0, wb_vld = 0;
  logic [WW-1:0] iss_warp = '0, wb_warp = '0;
  logic [RW-1:0] iss_dst = '0, wb_reg = '0;
  logic [W*S*RW-1:0] src_reg = '0;
  logic [W*S-1:0] src_vld = '0;
  logic [W-1:0] unit_busy = '0, bar_wait = '0;
  logic [W-1:0] eligible, raw_hazard;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  bit mp [W][R];
  logic [W-1:0] exp_e, exp_h;
  logic [31:0] seed = 32'h1d2c3b4a;

  always #5 clk = ~clk;

  warp_scoreboard #(.NUM_WARPS(W), .NUM_REGS(R), .NUM_SRC(S)) uut (
    .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_warp(iss_warp), .iss_dst(iss_dst),
    .iss_dst_vld(iss_dst_vld), .wb_vld(wb_vld), .wb_warp(wb_warp), .wb_reg(wb_reg),
    .src_reg(src_reg), .src_vld(src_vld), .unit_busy(unit_busy), .bar_wait(bar_wait),
    .eligible(eligible), .raw_hazard(raw_hazard));

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // One clock: the model takes the inputs seen at the rising edge,
  // the registered results are compared at the following falling edge.
  task automatic tick(input string tag);
    @(posedge clk);
    if (rst) begin
      for (int w = 0; w < W; w++) for (int r = 0; r < R; r++) mp[w][r] = 0;
      exp_e = '0; exp_h = '0;
    end else begin
      if (wb_vld) mp[wb_warp][wb_reg] = 0;
      if (iss_vld && iss_dst_vld) mp[iss_warp][iss_dst] = 1;
      for (int w = 0; w < W; w++) begin
        bit hz = 0;
        for (int s = 0; s < S; s++)
          if (src_vld[w*S+s] && mp[w][src_reg[(w*S+s)*RW +: RW]]) hz = 1;
        exp_h[w] = hz;
        exp_e[w] = !hz && !unit_busy[w] && !bar_wait[w];
      end
    end
    @(negedge clk);
    check({tag, " eligible"}, eligible, exp_e);
    check({tag, " raw_hazard"}, raw_hazard, exp_h);
  endtask

  task automatic set_src(input int w, input int s, input int r, input bit v);
    src_reg[(w*S+s)*RW +: RW] = RW'(r);
    src_vld[w*S+s] = v;
  endtask

  task automatic all_src0(input int r);
    src_vld = '0;
    for (int w = 0; w < W; w++) set_src(w, 0, r, 1'b1);
  endtask

  task automatic quiet();
    iss_vld = 0; iss_dst_vld = 0; wb_vld = 0;
  endtask

  task automatic issue(input int w, input int r);
    iss_vld = 1; iss_dst_vld = 1; iss_warp = WW'(w); iss_dst = RW'(r);
  endtask

  task automatic wback(input int w, input int r);
    wb_vld = 1; wb_warp = WW'(w); wb_reg = RW'(r);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    @(negedge clk);
    tick("R1 reset"); tick("R1 reset");
    check("R1 reset eligible zero", eligible, '0);
    rst = 0;
    for (int r = 0; r < R; r++) begin
      all_src0(r);
      tick("R1 clear");
      check("R1 all ready after reset", eligible, '1);
    end

    // R2 R4 R6: every warp and register pair
    for (int w = 0; w < W; w++) begin
      for (int r = 0; r < R; r++) begin
        all_src0(r); issue(w, r);
        tick("R2 R6 set");
        check("R2 R6 only issuing warp blocked", raw_hazard, W'(1) << w);
        quiet(); wback(w, r);
        tick("R4 clear");
        check("R4 freed", raw_hazard, '0);
        quiet();
      end
    end

    // R3: no destination written
    all_src0(4);
    iss_vld = 1; iss_dst_vld = 0; iss_warp = 2'd1; iss_dst = 3'd4;
    tick("R3 no dst");
    check("R3 no dst", raw_hazard, '0);
    iss_vld = 0; iss_dst_vld = 1;
    tick("R3 no issue");
    check("R3 no issue", raw_hazard, '0);
    quiet();

    // R5: set over clear
    issue(1, 3); wback(1, 3); all_src0(3);
    tick("R5 collide");
    check("R5 set wins", raw_hazard, 4'b0010);
    quiet(); wback(1, 3);
    tick("R5 later clear");
    check("R5 later clear", raw_hazard, '0);
    quiet();

    // R7: invalid slots ignored
    issue(2, 5); src_vld = '0;
    set_src(2, 0, 5, 1'b0); set_src(2, 1, 1, 1'b1);
    tick("R7 setup");
    quiet();
    tick("R7 invalid slot");
    check("R7 invalid slot ignored", eligible, '1);
    set_src(2, 1, 5, 1'b1);
    tick("R7 slot1 valid");
    check("R7 slot1 valid", raw_hazard, 4'b0100);
    wback(2, 5);
    tick("R7 cleanup");
    quiet();

    // R8 R9 masks
    src_vld = '0; unit_busy = 4'b0001;
    tick("R8 busy");
    check("R8 unit busy", eligible, 4'b1110);
    unit_busy = '0; bar_wait = 4'b1000;
    tick("R9 barrier");
    check("R9 barrier", eligible, 4'b0111);
    bar_wait = '0;
    tick("R9 release");
    check("R9 release", eligible, '1);

    // R10: writeback frees dependent immediately, same-cycle issue elsewhere
    issue(0, 2);
    tick("R10 setup");
    quiet(); wback(0, 2); issue(0, 6);
    src_vld = '0; set_src(0, 0, 2, 1'b1);
    tick("R10 same cycle");
    check("R10 no bubble", eligible, '1);
    quiet();

    // R11: busy reg 6 not read; R12 hazard independent of masks
    set_src(0, 0, 1, 1'b1); set_src(0, 1, 7, 1'b1);
    tick("R11 waw");
    check("R11 unrelated busy reg", eligible, '1);
    set_src(0, 1, 6, 1'b1); unit_busy = 4'b0001; bar_wait = 4'b0001;
    tick("R12 masks");
    check("R12 hazard seen under masks", raw_hazard, 4'b0001);
    unit_busy = '0; bar_wait = '0; wback(0, 6);
    tick("R12 cleanup");
    quiet();

    // Pseudo-random run against the model: R2 R4 R5 R8 R9
    for (int i = 0; i < 3000; i++) begin
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      iss_vld = seed[0]; iss_dst_vld = seed[1]; iss_warp = seed[3:2]; iss_dst = seed[6:4];
      wb_vld = seed[7]; wb_warp = seed[9:8]; wb_reg = seed[12:10];
      unit_busy = seed[16:13] & seed[20:17];
      bar_wait = seed[24:21] & seed[28:25];
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      src_reg = seed[W*S*RW-1:0];
      src_vld = seed[31:24];
      tick("R2 R4 R5 R8 R9 random");
    end

    finish_run();
  end

endmodule